// File: doc/BRIEF.md
# Cached DRAM Cycle Controller

This block is the synchronous control core for a DRAM that carries a one-row SRAM cache beside its array. A system clock samples the active-low strobes (row enable, column latch, write enable, refresh, chip select and output enable) and a read/write select. All of them pass through two-flop synchronizers, and the block works on edges of the synchronized values. When row enable falls, the block decodes the cycle type from the levels of the other strobes. It then issues single-cycle requests to a behavioural DRAM array: activate, cache fill, write, external-row refresh and internal refresh. It also drives a write port and a read port on the cache array.

A last-read-row register, 11 bits wide by default, holds the row that is now in the cache. It has a valid flag that reset clears. An incoming row is compared with it to tell a hit from a miss. The register is loaded only by a read miss. The register also supplies the row for cache reads, which need no row strobe: with chip select and output enable low, the cache is read at the held row and the column address. The column is either live (static column) or captured on the column-latch falling edge (page mode).

Timing windows are counted in clock cycles. The write-miss read blackout after row enable rises is set by a parameter.

Top module: `cdram_cycle_ctrl`

## Requirements
- R1: After reset, all request outputs are low, cache reads are disabled and the row register is invalid, so the first read cycle of any row, row 0 included, is a miss that issues a fill.
- R2: A row-enable fall with refresh high and read/write select low (0 = read) starts a read cycle. The cycle issues `dram_act` with the row. On a miss it also issues `dram_fill` and loads the row register. On a hit it issues no fill.
- R3: A write cycle is decoded only when row enable falls while read/write select (1 = write), column latch, write enable and refresh are all high. Inside it, one `dram_wr` is issued with the captured column each time column latch and write enable become low together. Either one low alone writes nothing.
- R4: On a write whose row misses the register, only the DRAM is written (`cache_wr` stays low) and the register keeps its row. On a write hit, `cache_wr` is asserted together with `dram_wr`.
- R5: A write cycle in which no write was performed ends, on the row-enable rise, in one `dram_ext_rfsh` of that cycle's row. No data is written and the register is not changed.
- R6: From the decode of a write miss until `WRR_CYC` clocks after the synchronized row-enable rise, `cache_rd_en` is held low whatever the state of output enable.
- R7: With chip select and output enable low and the register valid, `cache_rd_en` is high, with `cache_rd_row` equal to the held row. No row strobe is needed.
- R8: With column latch high, `cache_rd_col` follows the column address. After a column-latch fall, it holds the column captured at that fall until column latch rises again.
- R9: With chip select high, `standby` is high, row-enable falls start no cycle (no requests, no register load) and cache reads are disabled.
- R10: Refresh low at a row-enable fall issues `dram_int_rfsh` with the internal counter, zero-extended on `dram_row`. The counter starts at 0, increments when row enable rises and wraps modulo 2^`RFSH_W`.
- R11: Apart from the combinations in R2, R3 and R10, a row-enable fall with read/write select high and column latch or write enable low issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en_n | input | 1 | Row enable strobe, active low |
| col_lat_n | input | 1 | Column latch strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rfsh_n | input | 1 | Internal-refresh request, active low |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_sel | input | 1 | Read/write select, 1 = write |
| row_addr | input | ROW_W | Row address |
| col_addr | input | COL_W | Column address |
| dram_act | output | 1 | Row activate request pulse |
| dram_fill | output | 1 | Cache fill request pulse (read miss) |
| dram_wr | output | 1 | DRAM write request pulse |
| dram_ext_rfsh | output | 1 | Refresh of the externally given row |
| dram_int_rfsh | output | 1 | Refresh of the internal counter row |
| dram_row | output | ROW_W | Row for the current request |
| dram_col | output | COL_W | Column for the write request |
| cache_wr | output | 1 | Cache write-through pulse (write hit) |
| cache_rd_en | output | 1 | Cache read and output drive enable |
| cache_rd_row | output | ROW_W | Cache row, from the row register |
| cache_rd_col | output | COL_W | Cache read column |
| standby | output | 1 | Low-power standby indicator |

## Verification
The bench sweeps all sixteen strobe combinations at a row-enable fall. A decoder that ignored one strobe would issue an activate or refresh where none is due. It walks the refresh counter past its wrap, and a counter of the wrong width or with the wrong increment point shows as a wrong row. Write cycles with only one of column latch and write enable low must produce no write and must end in a row refresh. A design that treated either strobe alone as a write, or that forgot the refresh, would change the request counts. The write-miss read blackout is checked on the exact cycle it opens, and the reset row of 0 is read first to catch a latch compared without its valid flag.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_IREF  = 2'd3
  } cyc_e;
endpackage

// File: rtl/cdram_sync.sv
module cdram_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cdram_row_latch.sv
module cdram_row_latch #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  output logic [ROW_W-1:0] lrr,
  output logic             valid,
  output logic             hit
);
  logic [ROW_W-1:0] lrr_n;
  logic             valid_n;

  always_comb begin
    lrr_n   = lrr;
    valid_n = valid;
    if (load) begin
      lrr_n   = row_in;
      valid_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrr   <= '0;
      valid <= 1'b0;
    end else begin
      lrr   <= lrr_n;
      valid <= valid_n;
    end
  end

  assign hit = valid && (row_in == lrr);

  // R4
  lrr_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrr) |-> $past(load));
endmodule

// File: rtl/cdram_cycle_dec.sv
module cdram_cycle_dec
  import cdram_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 9,
  parameter int RFSH_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             re_s,
  input  logic             col_s,
  input  logic             we_s,
  input  logic             rfsh_s,
  input  logic             sel_s,
  input  logic             wsel_s,
  input  logic [ROW_W-1:0] row_s,
  input  logic [COL_W-1:0] col_addr_s,
  input  logic             hit,
  output logic             load_lrr,
  output logic             wmiss_busy,
  output logic             wmiss_end,
  output logic             act_q,
  output logic             fill_q,
  output logic             wr_q,
  output logic             cwr_q,
  output logic             ext_q,
  output logic             int_q,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q
);
  cyc_e              cyc_q, cyc_n;
  logic              re_d, wact_d;
  logic              whit_q, whit_n, wrote_q, wrote_n;
  logic [ROW_W-1:0]  crow_q, crow_n, row_n;
  logic [COL_W-1:0]  col_n;
  logic [RFSH_W-1:0] rcnt_q, rcnt_n;
  logic              act_n, fill_n, wr_n, cwr_n, ext_n, int_n;
  logic              re_fall, re_rise, wact, wstart;
  logic              dec_go, dec_iref, dec_wr, dec_rd;

  assign re_fall  = re_d && !re_s;
  assign re_rise  = !re_d && re_s;
  assign wact     = !col_s && !we_s;
  assign wstart   = (cyc_q == CYC_WRITE) && wact && !wact_d;
  assign dec_go   = re_fall && !sel_s;
  assign dec_iref = dec_go && !rfsh_s;
  assign dec_wr   = dec_go && rfsh_s && wsel_s && col_s && we_s;
  assign dec_rd   = dec_go && rfsh_s && !wsel_s;

  assign load_lrr   = dec_rd && !hit;
  assign wmiss_busy = ((cyc_q == CYC_WRITE) && !whit_q) || (dec_wr && !hit);
  assign wmiss_end  = re_rise && (cyc_q == CYC_WRITE) && !whit_q;

  always_comb begin
    cyc_n   = cyc_q;
    whit_n  = whit_q;
    wrote_n = wrote_q;
    crow_n  = crow_q;
    rcnt_n  = rcnt_q;
    row_n   = row_q;
    col_n   = col_q;
    act_n   = 1'b0;
    fill_n  = 1'b0;
    wr_n    = 1'b0;
    cwr_n   = 1'b0;
    ext_n   = 1'b0;
    int_n   = 1'b0;
    if (re_rise) begin
      if (cyc_q == CYC_WRITE && !wrote_q) begin
        ext_n = 1'b1;
        row_n = crow_q;
      end
      if (cyc_q == CYC_IREF) begin
        rcnt_n = rcnt_q + 1'b1;
      end
      cyc_n = CYC_IDLE;
    end else if (dec_iref) begin
      cyc_n = CYC_IREF;
      int_n = 1'b1;
      row_n = ROW_W'(rcnt_q);
    end else if (dec_wr) begin
      cyc_n   = CYC_WRITE;
      crow_n  = row_s;
      whit_n  = hit;
      wrote_n = 1'b0;
      act_n   = 1'b1;
      row_n   = row_s;
    end else if (dec_rd) begin
      cyc_n  = CYC_READ;
      crow_n = row_s;
      act_n  = 1'b1;
      fill_n = !hit;
      row_n  = row_s;
    end else if (wstart) begin
      wr_n    = 1'b1;
      cwr_n   = whit_q;
      wrote_n = 1'b1;
      col_n   = col_addr_s;
      row_n   = crow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= CYC_IDLE;
      re_d    <= 1'b1;
      wact_d  <= 1'b0;
      whit_q  <= 1'b0;
      wrote_q <= 1'b0;
      crow_q  <= '0;
      rcnt_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      act_q   <= 1'b0;
      fill_q  <= 1'b0;
      wr_q    <= 1'b0;
      cwr_q   <= 1'b0;
      ext_q   <= 1'b0;
      int_q   <= 1'b0;
    end else begin
      cyc_q   <= cyc_n;
      re_d    <= re_s;
      wact_d  <= wact;
      whit_q  <= whit_n;
      wrote_q <= wrote_n;
      crow_q  <= crow_n;
      rcnt_q  <= rcnt_n;
      row_q   <= row_n;
      col_q   <= col_n;
      act_q   <= act_n;
      fill_q  <= fill_n;
      wr_q    <= wr_n;
      cwr_q   <= cwr_n;
      ext_q   <= ext_n;
      int_q   <= int_n;
    end
  end

  // R3
  wr_in_write_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> ($past(cyc_q) == CYC_WRITE));

  // R4
  cache_wr_with_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwr_q |-> wr_q);

  // R10
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_q, wr_q, ext_q, int_q}));

  // R9
  standby_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re_fall && sel_s) |=> (!act_q && !int_q && !fill_q));
endmodule

// File: rtl/cdram_rd_path.sv
module cdram_rd_path #(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 9,
  parameter int WRR_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s,
  input  logic             oe_s,
  input  logic             col_s,
  input  logic [COL_W-1:0] col_addr_s,
  input  logic [ROW_W-1:0] lrr,
  input  logic             valid,
  input  logic             wmiss_busy,
  input  logic             wmiss_end,
  output logic             rd_en,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col
);
  localparam int CW = (WRR_CYC < 1) ? 1 : $clog2(WRR_CYC + 1);

  logic [CW-1:0]    blk_q, blk_n;
  logic             col_d, col_fall, blocked, rd_en_n;
  logic [COL_W-1:0] page_q, page_n, rd_col_n;

  assign col_fall = col_d && !col_s;
  assign blocked  = wmiss_busy || (blk_q != '0);

  always_comb begin
    blk_n = blk_q;
    if (wmiss_end) begin
      blk_n = CW'(WRR_CYC);
    end else if (blk_q != '0) begin
      blk_n = blk_q - 1'b1;
    end
    page_n = col_fall ? col_addr_s : page_q;
    if (col_s || col_fall) begin
      rd_col_n = col_addr_s;
    end else begin
      rd_col_n = page_q;
    end
    rd_en_n = !sel_s && !oe_s && valid && !blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      col_d  <= 1'b1;
      page_q <= '0;
      rd_en  <= 1'b0;
      rd_row <= '0;
      rd_col <= '0;
    end else begin
      blk_q  <= blk_n;
      col_d  <= col_s;
      page_q <= page_n;
      rd_en  <= rd_en_n;
      rd_row <= lrr;
      rd_col <= rd_col_n;
    end
  end

  // R6
  wmiss_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wmiss_busy |=> !rd_en);

  // R9
  sel_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !rd_en);

  // R8
  page_col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_s && !col_d && $past(!col_s)) |=> $stable(rd_col));
endmodule

// File: rtl/cdram_cycle_ctrl.sv
module cdram_cycle_ctrl #(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 9,
  parameter int RFSH_W  = 10,
  parameter int WRR_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_en_n,
  input  logic             col_lat_n,
  input  logic             wr_en_n,
  input  logic             rfsh_n,
  input  logic             sel_n,
  input  logic             oe_n,
  input  logic             wr_sel,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  output logic             dram_act,
  output logic             dram_fill,
  output logic             dram_wr,
  output logic             dram_ext_rfsh,
  output logic             dram_int_rfsh,
  output logic [ROW_W-1:0] dram_row,
  output logic [COL_W-1:0] dram_col,
  output logic             cache_wr,
  output logic             cache_rd_en,
  output logic [ROW_W-1:0] cache_rd_row,
  output logic [COL_W-1:0] cache_rd_col,
  output logic             standby
);
  localparam int NSTB = 7;
  localparam int AW   = ROW_W + COL_W;

  logic             rst_meta_q, rst_sync_n;
  logic [NSTB-1:0]  stb_s;
  logic [AW-1:0]    addr_s;
  logic             re_s, col_s, we_s, rf_s, sel_s, oe_s, ws_s;
  logic [ROW_W-1:0] row_s, lrr;
  logic [COL_W-1:0] cad_s;
  logic             valid, hit, load_lrr, wmiss_busy, wmiss_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cdram_sync #(.W(NSTB), .RST_VAL({NSTB{1'b1}})) stb_sync_i (
    .clk(clk), .rst_n(rst_sync_n),
    .d({row_en_n, col_lat_n, wr_en_n, rfsh_n, sel_n, oe_n, wr_sel}),
    .q(stb_s)
  );

  cdram_sync #(.W(AW), .RST_VAL('0)) addr_sync_i (
    .clk(clk), .rst_n(rst_sync_n), .d({row_addr, col_addr}), .q(addr_s)
  );

  assign {re_s, col_s, we_s, rf_s, sel_s, oe_s, ws_s} = stb_s;
  assign {row_s, cad_s} = addr_s;
  assign standby = sel_s;

  cdram_row_latch #(.ROW_W(ROW_W)) lrr_i (
    .clk(clk), .rst_n(rst_sync_n), .load(load_lrr), .row_in(row_s),
    .lrr(lrr), .valid(valid), .hit(hit)
  );

  cdram_cycle_dec #(.ROW_W(ROW_W), .COL_W(COL_W), .RFSH_W(RFSH_W)) dec_i (
    .clk(clk), .rst_n(rst_sync_n),
    .re_s(re_s), .col_s(col_s), .we_s(we_s), .rfsh_s(rf_s), .sel_s(sel_s),
    .wsel_s(ws_s), .row_s(row_s), .col_addr_s(cad_s), .hit(hit),
    .load_lrr(load_lrr), .wmiss_busy(wmiss_busy), .wmiss_end(wmiss_end),
    .act_q(dram_act), .fill_q(dram_fill), .wr_q(dram_wr), .cwr_q(cache_wr),
    .ext_q(dram_ext_rfsh), .int_q(dram_int_rfsh),
    .row_q(dram_row), .col_q(dram_col)
  );

  cdram_rd_path #(.ROW_W(ROW_W), .COL_W(COL_W), .WRR_CYC(WRR_CYC)) rd_i (
    .clk(clk), .rst_n(rst_sync_n),
    .sel_s(sel_s), .oe_s(oe_s), .col_s(col_s), .col_addr_s(cad_s),
    .lrr(lrr), .valid(valid), .wmiss_busy(wmiss_busy), .wmiss_end(wmiss_end),
    .rd_en(cache_rd_en), .rd_row(cache_rd_row), .rd_col(cache_rd_col)
  );
endmodule

// File: tb/cdram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module cdram_cycle_ctrl_tb_top;
  localparam int ROW_W = 11, COL_W = 9, RFSH_W = 10, WRR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_en_n = 1, col_lat_n = 1, wr_en_n = 1, rfsh_n = 1, sel_n = 0, oe_n = 1, wr_sel = 0;
  logic [ROW_W-1:0] row_addr = '0;
  logic [COL_W-1:0] col_addr = '0;
  logic dram_act, dram_fill, dram_wr, dram_ext_rfsh, dram_int_rfsh, cache_wr, cache_rd_en, standby;
  logic [ROW_W-1:0] dram_row, cache_rd_row;
  logic [COL_W-1:0] dram_col, cache_rd_col;

  int n_chk = 0, n_fail = 0;
  int n_act = 0, n_fill = 0, n_wr = 0, n_cwr = 0, n_ext = 0, n_int = 0;
  int fill_row = -1, int_row = -1, ext_row = -1, wr_row = -1, wr_col = -1;
  int exp_rc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cdram_cycle_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .RFSH_W(RFSH_W), .WRR_CYC(WRR)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .col_lat_n(col_lat_n), .wr_en_n(wr_en_n),
    .rfsh_n(rfsh_n), .sel_n(sel_n), .oe_n(oe_n), .wr_sel(wr_sel), .row_addr(row_addr),
    .col_addr(col_addr), .dram_act(dram_act), .dram_fill(dram_fill), .dram_wr(dram_wr),
    .dram_ext_rfsh(dram_ext_rfsh), .dram_int_rfsh(dram_int_rfsh), .dram_row(dram_row),
    .dram_col(dram_col), .cache_wr(cache_wr), .cache_rd_en(cache_rd_en),
    .cache_rd_row(cache_rd_row), .cache_rd_col(cache_rd_col), .standby(standby)
  );

  always @(negedge clk) begin
    if (dram_act) n_act++;
    if (dram_fill) begin n_fill++; fill_row = int'(dram_row); end
    if (dram_wr) begin n_wr++; wr_row = int'(dram_row); wr_col = int'(dram_col); end
    if (cache_wr) n_cwr++;
    if (dram_ext_rfsh) begin n_ext++; ext_row = int'(dram_row); end
    if (dram_int_rfsh) begin n_int++; int_row = int'(dram_row); end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic re_cycle(input bit ws, input bit c, input bit w, input bit rf, input int row);
    @(negedge clk);
    wr_sel = ws; col_lat_n = c; wr_en_n = w; rfsh_n = rf; row_addr = ROW_W'(row);
    row_en_n = 0;
    waitc(6);
    @(negedge clk);
    col_lat_n = 1; wr_en_n = 1; rfsh_n = 1;
    waitc(3);
    @(negedge clk);
    row_en_n = 1;
    waitc(WRR + 6);
  endtask

  task automatic wr_begin(input int row);
    @(negedge clk);
    wr_sel = 1; col_lat_n = 1; wr_en_n = 1; rfsh_n = 1; row_addr = ROW_W'(row);
    row_en_n = 0;
    waitc(5);
  endtask

  task automatic strobe(input bit c, input bit w, input int col);
    @(negedge clk);
    col_addr = COL_W'(col); col_lat_n = c; wr_en_n = w;
    waitc(4);
    @(negedge clk);
    col_lat_n = 1; wr_en_n = 1;
    waitc(3);
  endtask

  task automatic wr_end();
    @(negedge clk);
    row_en_n = 1;
    waitc(WRR + 6);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int a0, f0, w0, c0, e0, i0;
    waitc(5);
    @(negedge clk); rst_n = 1; oe_n = 0;
    waitc(6);
    // R1: reset state
    chk("R1 rd_en after reset", cache_rd_en, 0);
    chk("R1 no requests", n_act + n_fill + n_wr + n_ext + n_int, 0);
    chk("R1 standby low", standby, 0);
    re_cycle(0, 1, 1, 1, 0);
    chk("R1 first read row0 fills", n_fill, 1);
    chk("R1 fill row", fill_row, 0);
    chk("R7 rd_en after fill", cache_rd_en, 1);

    // R2 / R7: read miss then hit over many rows
    for (int i = 0; i < 24; i++) begin
      int r;
      r = (i * 677 + 5) % 2048;
      f0 = n_fill; a0 = n_act;
      re_cycle(0, 1, 1, 1, r);
      chk("R2 miss fill", n_fill - f0, 1);
      chk("R2 fill row", fill_row, r);
      chk("R7 cache row", int'(cache_rd_row), r);
      re_cycle(0, 1, 1, 1, r);
      chk("R2 hit no fill", n_fill - f0, 1);
      chk("R2 act count", n_act - a0, 2);
    end

    // R3 / R11 / R10: all strobe combinations at row-enable fall
    for (int c = 0; c < 16; c++) begin
      bit ws, cl, we, rf;
      {ws, cl, we, rf} = 4'(c);
      a0 = n_act; i0 = n_int; e0 = n_ext; w0 = n_wr;
      re_cycle(ws, cl, we, rf, 100 + c);
      if (!rf) begin
        chk("R10 combo int", n_int - i0, 1);
        chk("R10 combo row", int_row, exp_rc % 1024);
        exp_rc++;
        chk("R10 combo act", n_act - a0, 0);
      end else if (!ws) begin
        chk("R2 combo read act", n_act - a0, 1);
        chk("R2 combo read ext", n_ext - e0, 0);
      end else if (cl && we) begin
        chk("R3 combo write act", n_act - a0, 1);
        chk("R5 combo write ext", n_ext - e0, 1);
      end else begin
        chk("R11 combo none act", n_act - a0, 0);
        chk("R11 combo none int", n_int - i0, 0);
        chk("R11 combo none ext", n_ext - e0, 0);
      end
      chk("R3 combo no write", n_wr - w0, 0);
    end

    // R4: write miss, then hits, then burst
    re_cycle(0, 1, 1, 1, 300);
    w0 = n_wr; c0 = n_cwr; e0 = n_ext;
    wr_begin(400);
    chk("R6 rd blocked during write miss", cache_rd_en, 0);
    strobe(0, 0, 5);
    wr_end();
    chk("R4 miss write", n_wr - w0, 1);
    chk("R4 miss row", wr_row, 400);
    chk("R3 miss col", wr_col, 5);
    chk("R4 miss no cache_wr", n_cwr - c0, 0);
    chk("R4 miss no ext", n_ext - e0, 0);
    chk("R4 latch kept", int'(cache_rd_row), 300);
    wr_begin(300);
    chk("R7 rd kept on write hit", cache_rd_en, 1);
    strobe(0, 0, 7);
    wr_end();
    chk("R4 hit write", n_wr - w0, 2);
    chk("R4 hit cache_wr", n_cwr - c0, 1);
    wr_begin(300);
    for (int k = 1; k <= 3; k++) strobe(0, 0, k);
    wr_end();
    chk("R3 burst writes", n_wr - w0, 5);
    chk("R3 burst last col", wr_col, 3);
    chk("R4 burst cache_wr", n_cwr - c0, 4);

    // R3 / R5: only one strobe low -> no write, ends in refresh
    w0 = n_wr; e0 = n_ext;
    wr_begin(300);
    strobe(1, 0, 9);
    strobe(0, 1, 9);
    wr_end();
    chk("R3 single strobes no write", n_wr - w0, 0);
    chk("R5 ext refresh", n_ext - e0, 1);
    chk("R5 ext row", ext_row, 300);
    chk("R5 latch unchanged", int'(cache_rd_row), 300);

    // R6: read blackout window after write-miss end
    wr_begin(555);
    strobe(0, 0, 1);
    @(negedge clk);
    row_en_n = 1;
    repeat (3 + WRR) @(posedge clk);
    #5;
    chk("R6 still blocked", cache_rd_en, 0);
    @(posedge clk);
    #5;
    chk("R6 reads resume", cache_rd_en, 1);
    waitc(4);

    // R8: static column sweep, then page capture
    for (int v = 0; v < 512; v++) begin
      @(negedge clk); col_addr = COL_W'(v);
      waitc(3);
      chk("R8 static col", int'(cache_rd_col), v);
    end
    @(negedge clk); col_addr = 9'h055; col_lat_n = 0;
    waitc(4);
    chk("R8 page capture", int'(cache_rd_col), 'h55);
    @(negedge clk); col_addr = 9'h0AA;
    waitc(4);
    chk("R8 page hold", int'(cache_rd_col), 'h55);
    @(negedge clk); col_lat_n = 1;
    waitc(4);
    chk("R8 static again", int'(cache_rd_col), 'hAA);

    // R9: standby
    @(negedge clk); sel_n = 1;
    waitc(4);
    chk("R9 standby", standby, 1);
    chk("R9 rd disabled", cache_rd_en, 0);
    a0 = n_act; f0 = n_fill; i0 = n_int;
    re_cycle(0, 1, 1, 1, 700);
    re_cycle(1, 1, 1, 0, 700);
    chk("R9 no act", n_act - a0, 0);
    chk("R9 no int", n_int - i0, 0);
    @(negedge clk); sel_n = 0;
    waitc(4);
    chk("R9 standby off", standby, 0);
    re_cycle(0, 1, 1, 1, 700);
    chk("R9 ignored read not loaded", n_fill - f0, 1);

    // R10: internal refresh sweep past wrap
    for (int n = 0; n < 1030; n++) begin
      @(negedge clk); rfsh_n = 0; row_en_n = 0;
      waitc(4);
      @(negedge clk); rfsh_n = 1; row_en_n = 1;
      waitc(4);
      chk("R10 int row", int_row, exp_rc % 1024);
      exp_rc++;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule